// File: doc/BRIEF.md
# Checkerboard SRAM Self-Test Sequencer

This block is a hardware self-test engine for a byte-wide single-port SRAM. After a start pulse it visits every address from 0x0000 up to a top address (0xCFFF by default). At each address it writes one of two complementary byte patterns and waits a programmable settle time, so a weak cell has time to lose its charge. It then reads the byte back and compares it. It repeats the sequence with the other pattern. The first pattern depends on address parity, so neighbouring cells always hold opposite data. Page zero (0x0000–0x00FF) is swept completely before the remaining addresses.

The engine counts every location that passes both patterns. On the first miscompare it stops issuing memory requests, enters a halted failure state and holds the failing address, the expected byte and the byte read. These values stay valid until the next start. The memory side is a request channel and a separate read-return strobe. A request holds its address, direction and data stable until the memory accepts it with ready. The memory may stall for any number of cycles. Read data may come back any number of cycles after the read is accepted, as long as it arrives after the accepting edge. The engine keeps at most one read outstanding.

Top module: `ckb_sram_test`

## Requirements
- R1: After reset, busy, done and fail are low and good_count is 0.
- R2: The only values written are 0xA5 and 0x5A. An even address first receives 0xA5 and then 0x5A. An odd address first receives 0x5A and then 0xA5. Each write is followed by a read of the same address before the next write.
- R3: At least SETTLE_CYC+1 clock cycles separate the edge that accepts a write from the edge that accepts the matching read. No request is presented in the cycle after a write is accepted.
- R4: Addresses are visited in ascending order from 0x0000, so all of page zero (0x0000–0x00FF) is finished before any higher address. zero_page is high exactly while a request targets page zero.
- R5: While mem_req is high and mem_ready is low, the next cycle still has mem_req high, with mem_addr, mem_we and mem_wdata unchanged.
- R6: good_count rises by one for each location that passes both patterns. On a clean run, done goes high with fail low and good_count equal to LAST_ADDR+1.
- R7: On the first read that differs from the written pattern, fail goes high and done and busy stay low. No further request is issued. fail_addr, fail_exp and fail_act capture the address, the written byte and the byte read. good_count equals the number of locations below the failing one.
- R8: The failure diagnostics and fail stay unchanged until the next accepted start. Start clears them, and busy rises on the following cycle.
- R9: A start pulse while busy is high has no effect: the sweep continues without restarting and good_count never drops.
- R10: No request is issued while a read is awaiting its return strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a test when not busy |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | Sweep finished with no miscompare |
| fail | output | 1 | Halted on a miscompare |
| zero_page | output | 1 | Current target address lies in page zero |
| mem_req | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_we | output | 1 | 1 = write request, 0 = read request |
| mem_addr | output | ADDR_W | Request address |
| mem_wdata | output | DATA_W | Write data |
| mem_rvalid | input | 1 | Read data valid strobe |
| mem_rdata | input | DATA_W | Read data |
| good_count | output | CNT_W | Locations that passed both patterns |
| fail_addr | output | ADDR_W | Address of the first miscompare |
| fail_exp | output | DATA_W | Byte that was written there |
| fail_act | output | DATA_W | Byte that was read back |

## Verification
The sweep is first run against a perfect memory with no stalls and a one-cycle read return. This pins down the address order, the parity-dependent pattern order and the settle spacing without any handshake effects. A second clean run uses random ready stalls and random read latency, which separates correct back-pressure holding and single-outstanding-read behaviour from timing that only works by luck. The same run carries a stray start pulse to show that restarts are ignored. Stuck-bit faults are then injected, both at directed addresses in page zero and above it and at random addresses, bits and polarities. Each fault shows whether the engine halts on the right pattern pass, latches the right diagnostics and stops counting at the right location.

// File: rtl/ckb_pkg.sv
package ckb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WRITE,
    ST_SETTLE,
    ST_READ,
    ST_WAIT,
    ST_DONE,
    ST_FAIL
  } ckb_state_t;
endpackage

// File: rtl/ckb_addr_seq.sv
module ckb_addr_seq #(
  parameter int ADDR_W    = 16,
  parameter int LAST_ADDR = 'hCFFF,
  parameter int ZP_LAST   = 'h00FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              advance,
  output logic [ADDR_W-1:0] addr,
  output logic              is_last,
  output logic              in_zp
);
  localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(LAST_ADDR);
  localparam logic [ADDR_W-1:0] ZP_A   = ADDR_W'(ZP_LAST);

  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (clear)   addr_q <= '0;
    else if (advance) addr_q <= addr_q + 1'b1;
  end

  assign addr    = addr_q;
  assign is_last = (addr_q == LAST_A);
  assign in_zp   = (addr_q <= ZP_A);
endmodule

// File: rtl/ckb_settle_timer.sv
module ckb_settle_timer #(
  parameter int SETTLE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expired
);
  generate
    if (SETTLE_CYC > 1) begin : g_count
      localparam int TW = $clog2(SETTLE_CYC);
      localparam logic [TW-1:0] RELOAD = TW'(SETTLE_CYC - 1);
      logic [TW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load)           cnt_q <= RELOAD;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
      end

      assign expired = (cnt_q == '0);
    end else begin : g_single
      // one settle cycle: the settle state itself is the whole delay
      logic unused_ok;
      assign unused_ok = clk ^ rst_n ^ load;
      assign expired   = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/ckb_result.sv
module ckb_result #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              count_en,
  input  logic              capture,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [DATA_W-1:0] cur_exp,
  input  logic [DATA_W-1:0] cur_act,
  output logic [CNT_W-1:0]  good_count,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [DATA_W-1:0] fail_exp,
  output logic [DATA_W-1:0] fail_act
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      good_count <= '0;
      fail_addr  <= '0;
      fail_exp   <= '0;
      fail_act   <= '0;
    end else if (clear) begin
      good_count <= '0;
      fail_addr  <= '0;
      fail_exp   <= '0;
      fail_act   <= '0;
    end else begin
      if (count_en) good_count <= good_count + 1'b1;
      if (capture) begin
        fail_addr <= cur_addr;
        fail_exp  <= cur_exp;
        fail_act  <= cur_act;
      end
    end
  end
endmodule

// File: rtl/ckb_sram_test.sv
module ckb_sram_test #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int LAST_ADDR  = 'hCFFF,
  parameter int ZP_LAST    = 'h00FF,
  parameter int SETTLE_CYC = 4,
  parameter int PAT_A      = 'hA5,
  parameter int PAT_B      = 'h5A,
  localparam int CNT_W     = $clog2(LAST_ADDR + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic              zero_page,
  output logic              mem_req,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [CNT_W-1:0]  good_count,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [DATA_W-1:0] fail_exp,
  output logic [DATA_W-1:0] fail_act
);
  import ckb_pkg::*;

  localparam logic [DATA_W-1:0] PA = DATA_W'(PAT_A);
  localparam logic [DATA_W-1:0] PB = DATA_W'(PAT_B);

  ckb_state_t state_q, state_d;
  logic       second_q, second_d;

  logic              clear, advance, is_last, in_zp;
  logic              tmr_load, tmr_expired;
  logic              count_en, capture;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_pat;
  logic              idle_like;

  ckb_addr_seq #(
    .ADDR_W(ADDR_W), .LAST_ADDR(LAST_ADDR), .ZP_LAST(ZP_LAST)
  ) u_addr (
    .clk(clk), .rst_n(rst_n), .clear(clear), .advance(advance),
    .addr(cur_addr), .is_last(is_last), .in_zp(in_zp)
  );

  ckb_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .expired(tmr_expired)
  );

  ckb_result #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_res (
    .clk(clk), .rst_n(rst_n), .clear(clear), .count_en(count_en),
    .capture(capture), .cur_addr(cur_addr), .cur_exp(cur_pat),
    .cur_act(mem_rdata), .good_count(good_count), .fail_addr(fail_addr),
    .fail_exp(fail_exp), .fail_act(fail_act)
  );

  // parity of address and pass number pick the pattern
  assign cur_pat = (cur_addr[0] ^ second_q) ? PB : PA;

  assign idle_like = (state_q == ST_IDLE) || (state_q == ST_DONE) ||
                     (state_q == ST_FAIL);

  always_comb begin
    state_d  = state_q;
    second_d = second_q;
    clear    = 1'b0;
    advance  = 1'b0;
    tmr_load = 1'b0;
    count_en = 1'b0;
    capture  = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_DONE, ST_FAIL: begin
        if (start) begin
          clear    = 1'b1;
          second_d = 1'b0;
          state_d  = ST_WRITE;
        end
      end
      ST_WRITE: begin
        if (mem_ready) begin
          tmr_load = 1'b1;
          state_d  = ST_SETTLE;
        end
      end
      ST_SETTLE: begin
        if (tmr_expired) state_d = ST_READ;
      end
      ST_READ: begin
        if (mem_ready) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (mem_rvalid) begin
          if (mem_rdata != cur_pat) begin
            capture = 1'b1;
            state_d = ST_FAIL;
          end else if (!second_q) begin
            second_d = 1'b1;
            state_d  = ST_WRITE;
          end else begin
            count_en = 1'b1;
            second_d = 1'b0;
            if (is_last) begin
              state_d = ST_DONE;
            end else begin
              advance = 1'b1;
              state_d = ST_WRITE;
            end
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      second_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      second_q <= second_d;
    end
  end

  assign mem_req   = (state_q == ST_WRITE) || (state_q == ST_READ);
  assign mem_we    = (state_q == ST_WRITE);
  assign mem_addr  = cur_addr;
  assign mem_wdata = cur_pat;
  assign busy      = !idle_like;
  assign done      = (state_q == ST_DONE);
  assign fail      = (state_q == ST_FAIL);
  assign zero_page = busy && in_zp;
endmodule

// File: rtl/ckb_sram_test_chk.sv
module ckb_sram_test_chk #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int LAST_ADDR = 'hCFFF,
  parameter int ZP_LAST   = 'h00FF,
  parameter int PAT_A     = 'hA5,
  parameter int PAT_B     = 'h5A,
  parameter int CNT_W     = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              fail,
  input logic              zero_page,
  input logic              mem_req,
  input logic              mem_ready,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic [CNT_W-1:0]  good_count,
  input logic [ADDR_W-1:0] fail_addr,
  input logic [DATA_W-1:0] fail_exp,
  input logic [DATA_W-1:0] fail_act
);
  localparam logic [CNT_W-1:0]  FULL = CNT_W'(LAST_ADDR + 1);
  localparam logic [ADDR_W-1:0] ZPA  = ADDR_W'(ZP_LAST);
  localparam logic [DATA_W-1:0] PA   = DATA_W'(PAT_A);
  localparam logic [DATA_W-1:0] PB   = DATA_W'(PAT_B);

  a_r1_busy_excl: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!done && !fail));

  a_r2_pattern_set: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_wdata == PA || mem_wdata == PB));

  a_r3_gap_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_ready) |=> !mem_req);

  a_r4_zero_page_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_page && mem_req) |-> (mem_addr <= ZPA));

  a_r5_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  a_r6_done_count: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (good_count == FULL && !fail));

  a_r7_quiet_on_fail: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> !mem_req);

  a_r8_diag_held: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !start) |=> (fail && $stable(fail_addr) && $stable(fail_exp) &&
                          $stable(fail_act)));

  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (good_count >= $past(good_count)));
endmodule

bind ckb_sram_test ckb_sram_test_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LAST_ADDR(LAST_ADDR),
  .ZP_LAST(ZP_LAST), .PAT_A(PAT_A), .PAT_B(PAT_B), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .fail(fail), .zero_page(zero_page), .mem_req(mem_req),
  .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .good_count(good_count), .fail_addr(fail_addr),
  .fail_exp(fail_exp), .fail_act(fail_act)
);

// File: tb/ckb_sram_test_tb.sv
module ckb_sram_test_tb;
  localparam int LAST   = 'h03FF;
  localparam int SETTLE = 3;
  localparam int AW     = 16;
  localparam int CW     = $clog2(LAST + 2);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          busy, done, fail, zero_page;
  logic          mem_req, mem_we;
  logic          mem_ready = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata;
  logic          mem_rvalid = 1'b0;
  logic [7:0]    mem_rdata = 8'h00;
  logic [CW-1:0] good_count;
  logic [AW-1:0] fail_addr;
  logic [7:0]    fail_exp, fail_act;

  always #4 clk = ~clk;

  ckb_sram_test #(.ADDR_W(AW), .DATA_W(8), .LAST_ADDR(LAST),
                  .SETTLE_CYC(SETTLE)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .fail(fail), .zero_page(zero_page), .mem_req(mem_req),
    .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .good_count(good_count), .fail_addr(fail_addr), .fail_exp(fail_exp),
    .fail_act(fail_act)
  );

  int checks = 0;
  int fails  = 0;

  // memory model and monitor state
  logic [7:0] sram [0:LAST];
  int   ready_pct = 100;
  int   lat_max   = 1;
  bit   flt_en = 0;
  int   flt_addr = 0;
  logic [7:0] flt_mask = 8'h00, flt_val = 8'h00;
  bit   outstanding = 0;
  int   pend_cnt = 0;
  int   pend_addr = 0;
  int   exp_addr = 0;
  bit   exp_pass = 0;
  bit   exp_we = 1;
  longint cyc = 0, wcyc = 0;
  bit   prev_stall = 0;
  logic [AW-1:0] prev_addr;
  logic          prev_we;
  logic [7:0]    prev_wdata;
  int   err_seq = 0, err_settle = 0, err_hold = 0, err_out = 0, err_zp = 0;

  function automatic logic [7:0] first_pat(input int a);
    return a[0] ? 8'h5A : 8'hA5;
  endfunction

  function automatic logic [7:0] apply_fault(input int a, input logic [7:0] d);
    if (flt_en && a == flt_addr) return (d & ~flt_mask) | (flt_val & flt_mask);
    return d;
  endfunction

  function automatic bit predict_fail(input logic [7:0] m, input logic [7:0] v,
                                      input int a, output logic [7:0] e,
                                      output logic [7:0] r);
    for (int k = 0; k < 2; k++) begin
      logic [7:0] p, rd;
      p  = (k == 0) ? first_pat(a) : ~first_pat(a);
      rd = (p & ~m) | (v & m);
      if (rd != p) begin
        e = p; r = rd; return 1'b1;
      end
    end
    e = 8'h00; r = 8'h00;
    return 1'b0;
  endfunction

  always @(negedge clk) begin
    bit rdy;
    cyc++;
    mem_rvalid = 1'b0;
    // R10: nothing may be requested while a read is pending
    if (outstanding && mem_req) err_out++;
    if (outstanding) begin
      if (pend_cnt == 0) begin
        mem_rvalid  = 1'b1;
        mem_rdata   = apply_fault(pend_addr, sram[pend_addr]);
        outstanding = 0;
      end else pend_cnt--;
    end
    // R5: request held while stalled
    if (prev_stall && (!mem_req || mem_addr != prev_addr ||
                       mem_we != prev_we || mem_wdata != prev_wdata))
      err_hold++;
    // R4: zero page flag
    if (mem_req && (zero_page != (mem_addr <= 16'h00FF))) err_zp++;
    rdy = (($urandom % 100) < ready_pct);
    mem_ready = rdy;
    if (mem_req && rdy) begin
      if (int'(mem_addr) != exp_addr || mem_we != exp_we) err_seq++;
      if (mem_we) begin
        if (mem_wdata != (exp_pass ? ~first_pat(exp_addr) : first_pat(exp_addr)))
          err_seq++;
        sram[mem_addr] = mem_wdata;
        wcyc   = cyc;
        exp_we = 0;
      end else begin
        if (cyc - wcyc < SETTLE + 1) err_settle++;
        outstanding = 1;
        pend_cnt    = $urandom % lat_max;
        pend_addr   = int'(mem_addr);
        exp_we      = 1;
        if (!exp_pass) exp_pass = 1;
        else begin
          exp_pass = 0;
          exp_addr++;
        end
      end
    end
    prev_stall = mem_req && !rdy;
    prev_addr  = mem_addr;
    prev_we    = mem_we;
    prev_wdata = mem_wdata;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_mon();
    exp_addr = 0; exp_pass = 0; exp_we = 1;
    err_seq = 0; err_settle = 0; err_hold = 0; err_out = 0; err_zp = 0;
  endtask

  // pulse start, optionally pulse a stray start mid-run, wait for the end
  task automatic run(input int stray_at);
    int n;
    clear_mon();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    n = 0;
    while (!done && !fail && n < 60000) begin
      @(negedge clk);
      n++;
      if (n == stray_at) start = 1'b1;
      else start = 1'b0;
    end
    start = 1'b0;
    if (n >= 60000) chk(1'b0, "R6", "run timeout", n, 0);
    @(negedge clk);
  endtask

  task automatic fault_case(input int a, input logic [7:0] m,
                            input logic [7:0] v, input string tag);
    logic [7:0] e, r;
    bit will;
    will = predict_fail(m, v, a, e, r);
    flt_en = 1; flt_addr = a; flt_mask = m; flt_val = v;
    run(0);
    chk(fail == will, tag, "fail flag", fail, will);
    if (will) begin
      chk(!done && !busy, tag, "done/busy low", {done, busy}, 0);
      chk(fail_addr == a[AW-1:0], tag, "fail_addr", fail_addr, a);
      chk(fail_exp == e, tag, "fail_exp", fail_exp, e);
      chk(fail_act == r, tag, "fail_act", fail_act, r);
      chk(good_count == a[CW-1:0], tag, "good_count at halt", good_count, a);
    end
    flt_en = 0;
  endtask

  initial begin
    #(8 * 190000);
    checks++; fails++;
    $display("FAIL watchdog expired: actual hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    for (int i = 0; i <= LAST; i++) sram[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !fail, "R1", "flags in reset", {busy, done, fail}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !fail, "R1", "flags after reset", {busy, done, fail}, 0);
    chk(good_count == 0, "R1", "good_count after reset", good_count, 0);

    // clean run, no stalls
    ready_pct = 100; lat_max = 1;
    run(0);
    chk(done && !fail, "R6", "clean done", {done, fail}, 2);
    chk(good_count == LAST + 1, "R6", "clean count", good_count, LAST + 1);
    chk(err_seq == 0, "R2", "order/pattern errors", err_seq, 0);
    chk(exp_addr == LAST + 1, "R4", "addresses visited", exp_addr, LAST + 1);
    chk(err_settle == 0, "R3", "settle violations", err_settle, 0);
    chk(err_zp == 0, "R4", "zero_page flag errors", err_zp, 0);
    chk(err_out == 0, "R10", "request while read pending", err_out, 0);

    // random stalls, random read latency, stray start mid-run
    ready_pct = 55; lat_max = 4;
    run(700);
    chk(done && !fail, "R9", "done despite stray start", {done, fail}, 2);
    chk(good_count == LAST + 1, "R9", "count after stray start", good_count, LAST + 1);
    chk(err_seq == 0, "R9", "no restart in sequence", err_seq, 0);
    chk(err_hold == 0, "R5", "stall hold errors", err_hold, 0);
    chk(err_settle == 0, "R3", "settle under stalls", err_settle, 0);
    chk(err_out == 0, "R10", "pending read under stalls", err_out, 0);

    // directed faults: page zero second pass, and above page zero first pass
    ready_pct = 100; lat_max = 2;
    fault_case('h37, 8'h08, 8'h08, "R7");
    begin
      logic [AW-1:0] fa; logic [7:0] fe, fx;
      bit quiet;
      fa = fail_addr; fe = fail_exp; fx = fail_act; quiet = 1;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (mem_req || !fail || fail_addr != fa || fail_exp != fe || fail_act != fx)
          quiet = 0;
      end
      chk(quiet, "R8", "diagnostics held, no requests", quiet, 1);
    end
    fault_case('h2C4, 8'h01, 8'h00, "R7");

    // R8: a new start clears the halt
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy && !fail, "R8", "start clears fail", {busy, fail}, 2);
    chk(fail_addr == 0 && good_count == 0, "R8", "diag cleared",
        {fail_addr, good_count}, 0);
    while (!done && !fail) @(negedge clk);
    @(negedge clk);
    chk(done && good_count == LAST + 1, "R6", "clean rerun", good_count, LAST + 1);

    // random stuck bits
    ready_pct = 80; lat_max = 3;
    for (int t = 0; t < 3; t++) begin
      int a; logic [7:0] m, v;
      a = $urandom % (LAST + 1);
      m = 8'h01 << ($urandom % 8);
      v = ($urandom % 2) ? 8'hFF : 8'h00;
      fault_case(a, m, v, "R7");
      chk(err_seq == 0, "R2", "sequence before halt", err_seq, 0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule